// File: doc/BRIEF.md
# Two-by-Two Self-Routing Switch Element with Output Queues

This block is one node of a multistage self-routing fabric that carries fixed-length cells. Each cell moves in one clock cycle. The node has two input ports and two output ports, and each output port has its own queue. Every cycle the node reads the cells that are waiting on its inputs. It steers each cell by a single bit of the cell's destination address and admits the cells into the queues that have room.

Admission counts the slot that a departing head cell frees in the same cycle. Two cells that target the same queue are both taken when the queue has two or more free slots. When only one slot is free, a free-running pseudo-random bit picks the winner. A cell that is not admitted stays on its input, because its ready signal is held low. Under the handshake rule it is presented again on every following cycle until the node takes it, so the node never drops a cell. Each queue shows its oldest cell downstream through a valid/ready pair.

The parameters are the payload width, the address width, the stage index and the queue depth. A cell is the destination address followed by the payload.

Top module: `sw2_switch_elem`

## Requirements
- R1: After reset, and for as long as reset is held, both output valids are low and both queues are empty.
- R2: In stage STAGE the node routes a cell by destination bit ADDR_W-STAGE. A 0 sends the cell to output 0 and a 1 sends it to output 1. The other address bits have no effect on routing. The address and payload leave the node unchanged.
- R3: Two cells that target the same queue are both admitted in the same cycle when that queue has two or more free slots. Input 0's cell is queued ahead of input 1's cell.
- R4: Two cells that target the same queue, which has exactly one free slot, produce exactly one ready. The winner comes from a pseudo-random bit, and over repeated contention each input wins at least once.
- R5: When the target queue has no free slot, every cell that targets it sees ready low.
- R6: A full queue accepts one cell in a cycle where its head cell leaves, that is, when output valid and output ready are both high.
- R7: A cell that is refused stays on its input until it is accepted. Every cell presented to the node is delivered exactly once.
- R8: Output valid is high exactly when the queue is non-empty. The head cell stays stable while output ready is low, and each queue delivers its cells in arrival order.
- R9: Cells that target different queues are admitted independently in the same cycle, each according to its own queue's free space.
- R10: An input's ready is low whenever its valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in0_valid | input | 1 | Input 0 holds a cell |
| in0_ready | output | 1 | The node takes the cell on input 0 this cycle |
| in0_dest | input | ADDR_W | Destination address of the cell on input 0 |
| in0_data | input | DATA_W | Payload of the cell on input 0 |
| in1_valid | input | 1 | Input 1 holds a cell |
| in1_ready | output | 1 | The node takes the cell on input 1 this cycle |
| in1_dest | input | ADDR_W | Destination address of the cell on input 1 |
| in1_data | input | DATA_W | Payload of the cell on input 1 |
| out0_valid | output | 1 | Queue 0 has a head cell |
| out0_ready | input | 1 | The downstream stage takes the head of queue 0 |
| out0_dest | output | ADDR_W | Destination address of the head of queue 0 |
| out0_data | output | DATA_W | Payload of the head of queue 0 |
| out1_valid | output | 1 | Queue 1 has a head cell |
| out1_ready | input | 1 | The downstream stage takes the head of queue 1 |
| out1_dest | output | ADDR_W | Destination address of the head of queue 1 |
| out1_data | output | DATA_W | Payload of the head of queue 1 |

## Verification
Several rules are checked on every cycle:
- no queue ever holds more than its depth;
- a full queue takes a cell only in a cycle when its head leaves;
- a stalled head cell keeps its value;
- a ready is never raised without a valid;
- a refused cell is held on its input;
- the tie-break generator never locks up.

Other behaviour needs the bench's scenarios, which compare the node against a queue model:
- the exact choice between both, one or no admissions for each amount of free space;
- routing by the selected address bit;
- the order of cells within each queue;
- both inputs winning ties over repeated contention;
- the end-to-end count showing that no cell is lost.

// File: rtl/sw2_pkg.sv
package sw2_pkg;

   // Outcome of admission for one output queue in one cycle.
   typedef enum logic [1:0] {
      GR_NONE = 2'd0,
      GR_IN0  = 2'd1,
      GR_IN1  = 2'd2,
      GR_BOTH = 2'd3
   } grant_e;

   // Tie-break generator: Galois shift register with a maximal-length feedback mask.
   localparam int          TIE_W    = 16;
   localparam logic [15:0] TIE_MASK = 16'hB400;
   localparam logic [15:0] TIE_SEED = 16'hACE1;

   function automatic logic takes_in0(grant_e g);
      return (g == GR_IN0) || (g == GR_BOTH);
   endfunction

   function automatic logic takes_in1(grant_e g);
      return (g == GR_IN1) || (g == GR_BOTH);
   endfunction

endpackage

// File: rtl/sw2_lfsr.sv
module sw2_lfsr #(
   parameter int          W    = 16,
   parameter logic [W-1:0] MASK = '1,
   parameter logic [W-1:0] SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tie_bit
);

   logic [W-1:0] state;

   generate
      if (W < 3) begin : g_bad_w
         $error("sw2_lfsr: W must be at least 3");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("sw2_lfsr: SEED must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (state[0]) begin
         state <= (state >> 1) ^ MASK;
      end else begin
         state <= state >> 1;
      end
   end

   assign tie_bit = state[0];

   // R4: the generator never falls into the all-zero lock-up state
   a_r4_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/sw2_admit.sv
module sw2_admit
   import sw2_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             want0,
   input  logic             want1,
   input  logic [CNT_W-1:0] count,
   input  logic             drain,
   input  logic             tie_bit,
   output grant_e           grant
);

   int free_slots;

   always_comb begin
      free_slots = DEPTH - int'(count) + ((drain && (count != '0)) ? 1 : 0);
   end

   always_comb begin
      grant = GR_NONE;
      if (want0 && want1) begin
         if (free_slots >= 2) begin
            grant = GR_BOTH;
         end else if (free_slots == 1) begin
            grant = tie_bit ? GR_IN1 : GR_IN0;
         end
      end else if (want0) begin
         if (free_slots >= 1) grant = GR_IN0;
      end else if (want1) begin
         if (free_slots >= 1) grant = GR_IN1;
      end
   end

   // R10: a queue never grants an input that is not asking for it
   a_r10_grant_needs_want: assert property (@(posedge clk) disable iff (!rst_n)
      (takes_in0(grant) -> want0) && (takes_in1(grant) -> want1));

endmodule

// File: rtl/sw2_fifo.sv
module sw2_fifo #(
   parameter int CELL_W = 11,
   parameter int DEPTH  = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        push_cnt,
   input  logic [CELL_W-1:0] push_a,
   input  logic [CELL_W-1:0] push_b,
   input  logic              pop_rdy,
   output logic              head_valid,
   output logic [CELL_W-1:0] head,
   output logic [CNT_W-1:0]  count
);

   logic [CELL_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  rd_ptr, rd_nxt, wa, wb;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              pop;

   assign head_valid = (count != '0);
   assign head       = mem[rd_ptr];
   assign pop        = head_valid && pop_rdy;

   always_comb begin
      int a, b;
      a = int'(rd_ptr) + int'(count);
      if (a >= DEPTH) a = a - DEPTH;
      b = a + 1;
      if (b >= DEPTH) b = b - DEPTH;
      wa = IDX_W'(a);
      wb = IDX_W'(b);
      rd_nxt  = (int'(rd_ptr) + 1 >= DEPTH) ? '0 : rd_ptr + 1'b1;
      cnt_nxt = CNT_W'(int'(count) + int'(push_cnt) - (pop ? 1 : 0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (pop) rd_ptr <= rd_nxt;
         count <= cnt_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (push_cnt != 2'd0) mem[wa] <= push_a;
      if (push_cnt == 2'd2) mem[wb] <= push_b;
   end

   // R6: occupancy never exceeds the depth
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);

   // R6: a full queue takes a cell only while its head departs
   a_r6_full_needs_departure: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(count) == DEPTH && push_cnt != 2'd0) |-> pop);

   // R8: a stalled head cell is held stable
   a_r8_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !pop_rdy) |=> (head_valid && $stable(head)));

endmodule

// File: rtl/sw2_switch_elem.sv
module sw2_switch_elem
   import sw2_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int STAGE  = 1,
   parameter int DEPTH  = 4,
   localparam int CELL_W  = ADDR_W + DATA_W,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int SEL_BIT = ADDR_W - STAGE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in0_valid,
   output logic              in0_ready,
   input  logic [ADDR_W-1:0] in0_dest,
   input  logic [DATA_W-1:0] in0_data,
   input  logic              in1_valid,
   output logic              in1_ready,
   input  logic [ADDR_W-1:0] in1_dest,
   input  logic [DATA_W-1:0] in1_data,
   output logic              out0_valid,
   input  logic              out0_ready,
   output logic [ADDR_W-1:0] out0_dest,
   output logic [DATA_W-1:0] out0_data,
   output logic              out1_valid,
   input  logic              out1_ready,
   output logic [ADDR_W-1:0] out1_dest,
   output logic [DATA_W-1:0] out1_data
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("sw2_switch_elem: DATA_W must be positive");
      end
      if (STAGE < 1 || STAGE > ADDR_W) begin : g_bad_stage
         $error("sw2_switch_elem: STAGE must lie in 1..ADDR_W");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("sw2_switch_elem: DEPTH must be at least 2");
      end
   endgenerate

   logic [1:0]        route;
   logic [CELL_W-1:0] cell_in [2];
   logic [CELL_W-1:0] o_head  [2];
   logic [1:0]        o_valid, o_ready;
   logic [1:0]        take0, take1;
   logic              tie_bit;

   assign route[0]   = in0_dest[SEL_BIT];
   assign route[1]   = in1_dest[SEL_BIT];
   assign cell_in[0] = {in0_dest, in0_data};
   assign cell_in[1] = {in1_dest, in1_data};
   assign o_ready    = {out1_ready, out0_ready};

   sw2_lfsr #(
      .W    (TIE_W),
      .MASK (TIE_MASK),
      .SEED (TIE_SEED)
   ) u_tie (
      .clk     (clk),
      .rst_n   (rst_n),
      .tie_bit (tie_bit)
   );

   for (genvar p = 0; p < 2; p++) begin : g_port
      logic              want0, want1;
      logic [CNT_W-1:0]  cnt;
      logic [1:0]        push_cnt;
      logic [CELL_W-1:0] push_a;
      grant_e            grant;

      assign want0 = in0_valid && (route[0] == 1'(p));
      assign want1 = in1_valid && (route[1] == 1'(p));

      sw2_admit #(.DEPTH(DEPTH)) u_admit (
         .clk     (clk),
         .rst_n   (rst_n),
         .want0   (want0),
         .want1   (want1),
         .count   (cnt),
         .drain   (o_ready[p]),
         .tie_bit (tie_bit),
         .grant   (grant)
      );

      assign take0[p]  = takes_in0(grant);
      assign take1[p]  = takes_in1(grant);
      assign push_cnt  = {1'b0, take0[p]} + {1'b0, take1[p]};
      assign push_a    = take0[p] ? cell_in[0] : cell_in[1];

      sw2_fifo #(.CELL_W(CELL_W), .DEPTH(DEPTH)) u_queue (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_cnt   (push_cnt),
         .push_a     (push_a),
         .push_b     (cell_in[1]),
         .pop_rdy    (o_ready[p]),
         .head_valid (o_valid[p]),
         .head       (o_head[p]),
         .count      (cnt)
      );
   end

   assign in0_ready = |take0;
   assign in1_ready = |take1;

   assign out0_valid             = o_valid[0];
   assign out1_valid             = o_valid[1];
   assign {out0_dest, out0_data} = o_head[0];
   assign {out1_dest, out1_data} = o_head[1];

   // R10: ready is never raised toward an idle input
   a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (in0_ready -> in0_valid) && (in1_ready -> in1_valid));

   // R1: the first cycle after reset shows both queues empty
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!out0_valid && !out1_valid));

   // R7: a refused cell stays on its input, unchanged
   a_r7_blocked_retries: assert property (@(posedge clk) disable iff (!rst_n)
      (in0_valid && !in0_ready) |=> (in0_valid && $stable(in0_dest) && $stable(in0_data)));

   a_r7_blocked_retries_in1: assert property (@(posedge clk) disable iff (!rst_n)
      (in1_valid && !in1_ready) |=> (in1_valid && $stable(in1_dest) && $stable(in1_data)));

endmodule

// File: tb/sw2_switch_elem_test.sv
`timescale 1ns/1ps
module sw2_switch_elem_test;

   localparam int DW = 8;
   localparam int AW = 3;
   localparam int QD = 2;
   localparam int CW = AW + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in0_valid = 1'b0, in1_valid = 1'b0;
   logic          in0_ready, in1_ready;
   logic [AW-1:0] in0_dest = '0, in1_dest = '0;
   logic [DW-1:0] in0_data = '0, in1_data = '0;
   logic          out0_valid, out1_valid;
   logic          out0_ready = 1'b0, out1_ready = 1'b0;
   logic [AW-1:0] out0_dest, out1_dest;
   logic [DW-1:0] out0_data, out1_data;

   always #2.5 clk = ~clk;

   sw2_switch_elem #(.DATA_W(DW), .ADDR_W(AW), .STAGE(1), .DEPTH(QD)) uut (
      .clk(clk), .rst_n(rst_n),
      .in0_valid(in0_valid), .in0_ready(in0_ready), .in0_dest(in0_dest), .in0_data(in0_data),
      .in1_valid(in1_valid), .in1_ready(in1_ready), .in1_dest(in1_dest), .in1_data(in1_data),
      .out0_valid(out0_valid), .out0_ready(out0_ready), .out0_dest(out0_dest), .out0_data(out0_data),
      .out1_valid(out1_valid), .out1_ready(out1_ready), .out1_dest(out1_dest), .out1_data(out1_data)
   );

   int n_chk = 0, n_fail = 0;
   int seq = 1, presented = 0, delivered = 0;
   int tie_w0 = 0, tie_w1 = 0;
   bit hold0 = 0, hold1 = 0;
   logic [CW-1:0] q0[$];
   logic [CW-1:0] q1[$];

   // Stimulus table: {in0 valid, in0 port, in1 valid, in1 port, out0 ready, out1 ready}
   localparam int NV = 14;
   localparam logic [5:0] VEC [NV] = '{
      6'b1_0_1_0_0_0,  // both to queue 0 with room for two (R3)
      6'b1_0_1_0_0_0,  // queue 0 full, no departure (R5)
      6'b0_0_0_0_1_0,  // held cells retry while queue 0 drains (R6)
      6'b1_1_1_1_0_0,  // both to queue 1 (R3)
      6'b1_0_1_1_1_1,  // different queues (R9)
      6'b0_0_0_0_1_1,
      6'b0_0_0_0_1_1,
      6'b1_1_1_0_0_0,  // cross routing (R9)
      6'b1_0_1_0_0_1,  // one slot left in queue 0 (R4)
      6'b0_0_0_0_0_1,
      6'b1_1_0_0_0_0,
      6'b0_0_1_1_0_1,  // full queue 1 with departure (R6)
      6'b0_0_0_0_1_1,
      6'b0_0_0_0_1_1
   };

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // One cycle: drive at the falling edge, check before the next rising edge.
   task automatic step(input bit nv0, input bit np0, input bit nv1, input bit np1,
                       input bit or0, input bit or1);
      bit vv[2], pp[2], rdy[2], ordy[2], ex[2];
      string tg[2];
      if (!hold0) begin
         in0_valid = nv0;
         in0_dest  = {np0, 2'(seq)};
         in0_data  = DW'(seq);
         if (nv0) presented++;
         seq++;
      end
      if (!hold1) begin
         in1_valid = nv1;
         in1_dest  = {np1, 2'(seq + 1)};
         in1_data  = DW'(seq);
         if (nv1) presented++;
         seq++;
      end
      out0_ready = or0;
      out1_ready = or1;
      #1;
      vv[0] = in0_valid;  vv[1] = in1_valid;
      pp[0] = in0_dest[AW-1]; pp[1] = in1_dest[AW-1];
      rdy[0] = in0_ready; rdy[1] = in1_ready;
      ordy[0] = or0; ordy[1] = or1;
      ex[0] = 0; ex[1] = 0;
      tg[0] = "R10"; tg[1] = "R10";
      for (int p = 0; p < 2; p++) begin
         int c, f;
         bit w0, w1;
         c = (p == 0) ? q0.size() : q1.size();
         f = QD - c + ((ordy[p] && c > 0) ? 1 : 0);
         w0 = vv[0] && (pp[0] == 1'(p));
         w1 = vv[1] && (pp[1] == 1'(p));
         if (w0 && w1) begin
            if (f >= 2) begin
               ex[0] = 1; ex[1] = 1; tg[0] = "R3"; tg[1] = "R3";
            end else if (f == 0) begin
               tg[0] = "R5"; tg[1] = "R5";
            end else begin
               chk(rdy[0] ^ rdy[1], "R4", "ready count on single slot", int'(rdy[0]) + int'(rdy[1]), 1);
               ex[0] = rdy[0]; ex[1] = rdy[1]; tg[0] = "R4"; tg[1] = "R4";
               if (rdy[0]) tie_w0++;
               else if (rdy[1]) tie_w1++;
            end
         end else begin
            for (int i = 0; i < 2; i++) begin
               if ((i == 0 && w0) || (i == 1 && w1)) begin
                  ex[i] = (f >= 1);
                  tg[i] = (c == QD && ordy[p]) ? "R6" : ((f == 0) ? "R5" : "R9");
               end
            end
         end
      end
      chk(rdy[0] == ex[0], tg[0], "in0_ready", rdy[0], ex[0]);
      chk(rdy[1] == ex[1], tg[1], "in1_ready", rdy[1], ex[1]);
      // Output side against the queue model
      chk(out0_valid == (q0.size() > 0), "R8", "out0_valid", out0_valid, q0.size() > 0);
      chk(out1_valid == (q1.size() > 0), "R8", "out1_valid", out1_valid, q1.size() > 0);
      if (q0.size() > 0)
         chk({out0_dest, out0_data} == q0[0], "R2", "out0 cell", int'({out0_dest, out0_data}), int'(q0[0]));
      if (q1.size() > 0)
         chk({out1_dest, out1_data} == q1[0], "R2", "out1 cell", int'({out1_dest, out1_data}), int'(q1[0]));
      // Model update: departures, then arrivals with input 0 first
      if (out0_valid && or0 && q0.size() > 0) begin void'(q0.pop_front()); delivered++; end
      if (out1_valid && or1 && q1.size() > 0) begin void'(q1.pop_front()); delivered++; end
      if (vv[0] && rdy[0]) begin
         if (pp[0]) q1.push_back({in0_dest, in0_data}); else q0.push_back({in0_dest, in0_data});
      end
      if (vv[1] && rdy[1]) begin
         if (pp[1]) q1.push_back({in1_dest, in1_data}); else q0.push_back({in1_dest, in1_data});
      end
      hold0 = vv[0] && !rdy[0];
      hold1 = vv[1] && !rdy[1];
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drain();
      int guard = 0;
      while ((q0.size() != 0 || q1.size() != 0 || hold0 || hold1) && guard < 50) begin
         step(0, 0, 0, 0, 1, 1);
         guard++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: state while reset is held
      chk(!out0_valid && !out1_valid, "R1", "out valids in reset", out0_valid + out1_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out0_valid && !out1_valid, "R1", "out valids after reset", out0_valid + out1_valid, 0);
      chk(!in0_ready && !in1_ready, "R10", "readies while idle", in0_ready + in1_ready, 0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end
      drain();

      // R4: repeated single-slot contention, both inputs must win sometimes
      for (int t = 0; t < 24; t++) begin
         step(1, 0, 0, 0, 0, 0);
         step(1, 0, 1, 0, 0, 0);
         drain();
      end
      chk(tie_w0 > 0, "R4", "ties won by input 0", tie_w0, 1);
      chk(tie_w1 > 0, "R4", "ties won by input 1", tie_w1, 1);

      // R7: every presented cell was delivered exactly once
      chk(delivered == presented, "R7", "cells delivered", delivered, presented);

      // R1: reset in the middle of traffic empties both queues
      step(1, 1, 1, 1, 0, 0);
      rst_n = 1'b0;
      in0_valid = 1'b0;
      in1_valid = 1'b0;
      hold0 = 0;
      hold1 = 0;
      q0.delete();
      q1.delete();
      @(negedge clk);
      chk(!out0_valid && !out1_valid, "R1", "out valids after mid-run reset", out0_valid + out1_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      step(1, 0, 0, 0, 0, 0);
      drain();

      summary();
      $finish;
   end

endmodule